// File: doc/BRIEF.md
# Three-Stage Memory Fill Engine

This block fills a range of bytes in memory with one repeated value. A host runs it as three stages in a fixed order: prologue, main, epilogue. For each stage the host presents the destination-address value, the size value, the fill byte and the four condition flags. It then pulses a command. When the engine signals completion, the host takes the updated address, size and flags, and presents them as the inputs of the next stage.

A strap selects one of two register conventions.

- **Count-up form (strap low):** the prologue advances the address to the end of the range and negates the size. Every write then lands at address plus size, and the size climbs toward zero.
- **Count-down form (strap high):** the size stays positive and the address moves forward with each write.

The prologue records the form in the carry flag. The later stages refuse to run when that flag disagrees with the strap.

Writes leave through a port that carries up to eight bytes per beat with byte strobes. Each write gets a fault response. If a write faults, the engine stops, and the returned registers count only the beats that completed, so the host can resume.

Top module: `fill_seq`

## Requirements
- R1: Every byte lane written by the engine carries `fillByte`.
- R2: In the prologue, a size with bit 63 set is first replaced by 0x7FFF_FFFF_FFFF_FFFF.
- R3: A prologue with `optB`=0 returns address = start + size and size = −(bytes still to write). It returns flags 4'b0000, with the bit order {N,Z,C,V} and C at bit 1.
- R4: A prologue with `optB`=1 returns address = start + bytes written, size = bytes still to write, and flags 4'b0010.
- R5: With `optB`=0, each beat writes at address + size and adds the bytes written to the size. The address is left unchanged.
- R6: With `optB`=1, each beat writes at the address, adds the bytes written to the address, and subtracts them from the size.
- R7: A beat covers one contiguous run of 1 to 8 byte lanes inside one 8-byte-aligned word, and never exceeds the bytes remaining. The prologue writes only the bytes up to the first 8-byte boundary.
- R8: The main stage writes only while 64 or more bytes remain, and it stops as soon as fewer than 64 remain.
- R9: The epilogue writes every remaining byte and returns size 0.
- R10: A write answered with `wrFault` commits none of its bytes. The stage then ends with `fault` set, and the returned registers count only completed beats, so a repeated epilogue finishes the job.
- R11: `cmdStage` 2'b11 (00 prologue, 01 main, 10 epilogue) sets `errUndef`, performs no write, and returns the inputs unchanged.
- R12: In main or epilogue, a carry flag different from `optB` sets `errMismatch`, performs no write, and returns the inputs unchanged.
- R13: While `wrAck` is low, the pending beat holds its address, data and strobes. `wrNonTemp` and `wrUnpriv` repeat the bits given with the command.
- R14: After reset the engine is idle with no write pending. `done` is a single-cycle pulse that ends each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Start a stage (accepted when idle) |
| cmdStage | input | 2 | Stage code: 00 prologue, 01 main, 10 epilogue |
| cmdNonTemp | input | 1 | Nontemporal hint for this stage's writes |
| cmdUnpriv | input | 1 | Unprivileged-access hint for this stage's writes |
| optB | input | 1 | Convention strap: 0 count-up, 1 count-down |
| inAddr | input | 64 | Destination-address value |
| inSize | input | 64 | Size value |
| fillByte | input | 8 | Fill value (low byte of the data register) |
| inFlags | input | 4 | Flags {N,Z,C,V} |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| errUndef | output | 1 | Last command had an undefined stage code |
| errMismatch | output | 1 | Last command had a carry/strap mismatch |
| fault | output | 1 | Last command ended on a faulted write |
| outAddr | output | 64 | Updated address value |
| outSize | output | 64 | Updated size value |
| outFlags | output | 4 | Updated flags |
| wrValid | output | 1 | Write beat pending |
| wrAck | input | 1 | Beat accepted this cycle |
| wrFault | input | 1 | Accepted beat failed |
| wrAddr | output | 64 | 8-byte-aligned beat address |
| wrData | output | 64 | Beat data |
| wrStrb | output | 8 | Byte-lane strobes |
| wrNonTemp | output | 1 | Nontemporal sideband |
| wrUnpriv | output | 1 | Unprivileged sideband |

## Verification
The properties assume the following about the host:

- `optB` changes only while the engine is idle.
- `cmdValid` is raised only when `busy` is low.
- `wrFault` is meaningful only together with `wrAck`.

The stimulus honours all three. The strap and command inputs are changed only between commands, and the memory responder raises the fault only on an accepted beat.

The sweep covers both conventions, start offsets across and past one word, and lengths around the 8-byte and 64-byte edges, with and without back-pressure. Each stage's outputs are fed into the next stage's inputs, as a host would do.

// File: rtl/fill_pkg.sv
package fill_pkg;
  typedef enum logic [1:0] {
    STG_PRO  = 2'b00,
    STG_MAIN = 2'b01,
    STG_EPI  = 2'b10,
    STG_BAD  = 2'b11
  } stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic step;
  } dpCtl_t;

  localparam logic [3:0] FLAGS_UP   = 4'b0000;
  localparam logic [3:0] FLAGS_DOWN = 4'b0010;
  localparam int         C_BIT      = 1;
endpackage

// File: rtl/fill_dp.sv
module fill_dp
  import fill_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int BEAT_BYTES = 8,
  parameter int MAIN_FLOOR = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [1:0]              loadStage,
  input  stage_e                  runStage,
  input  logic                    optB,
  input  logic [XLEN-1:0]         inAddr,
  input  logic [XLEN-1:0]         inSize,
  input  logic [7:0]              fillByte,
  input  logic [3:0]              inFlags,
  output logic [XLEN-1:0]         addrQ,
  output logic [XLEN-1:0]         sizeQ,
  output logic [3:0]              flagsQ,
  output logic                    more,
  output logic [XLEN-1:0]         wrAddr,
  output logic [8*BEAT_BYTES-1:0] wrData,
  output logic [BEAT_BYTES-1:0]   wrStrb
);
  localparam int OFF_W = $clog2(BEAT_BYTES);
  localparam int CNT_W = OFF_W + 1;
  localparam logic [XLEN-1:0]        SAT_SIZE = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic signed [XLEN-1:0] FLOOR    = XLEN'(MAIN_FLOOR);
  localparam logic signed [XLEN-1:0] ZERO     = '0;

  logic [7:0]              fillQ;
  logic signed [XLEN-1:0]  remain;
  logic [XLEN-1:0]         curAddr;
  logic [XLEN-1:0]         satSize;
  logic [XLEN-1:0]         chunkX;
  logic [OFF_W-1:0]        offs;
  logic [CNT_W-1:0]        room;
  logic [CNT_W-1:0]        chunk;
  logic [CNT_W-1:0]        laneEnd;

  // bytes still owed and where the next byte goes, per convention
  always_comb begin
    remain  = optB ? $signed(sizeQ) : -$signed(sizeQ);
    curAddr = optB ? addrQ : addrQ + sizeQ;
    offs    = curAddr[OFF_W-1:0];
    room    = CNT_W'(BEAT_BYTES) - CNT_W'(offs);
    chunk   = (remain < $signed(XLEN'(room))) ? remain[CNT_W-1:0] : room;
    chunkX  = XLEN'(chunk);
    laneEnd = CNT_W'(offs) + chunk;
    satSize = inSize[XLEN-1] ? SAT_SIZE : inSize;
  end

  // stage-dependent continuation test
  always_comb begin
    unique case (runStage)
      STG_PRO:  more = (remain > ZERO) && (offs != '0);
      STG_MAIN: more = (remain >= FLOOR);
      STG_EPI:  more = (remain > ZERO);
      default:  more = 1'b0;
    endcase
  end

  assign wrAddr = {curAddr[XLEN-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar lane = 0; lane < BEAT_BYTES; lane++) begin : g_lane
    assign wrData[8*lane +: 8] = fillQ;
    assign wrStrb[lane] = (CNT_W'(lane) >= CNT_W'(offs)) && (CNT_W'(lane) < laneEnd);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      sizeQ  <= '0;
      flagsQ <= '0;
      fillQ  <= '0;
    end else if (ctl.load) begin
      fillQ <= fillByte;
      if (stage_e'(loadStage) == STG_PRO) begin
        if (optB) begin
          addrQ  <= inAddr;
          sizeQ  <= satSize;
          flagsQ <= FLAGS_DOWN;
        end else begin
          addrQ  <= inAddr + satSize;
          sizeQ  <= -satSize;
          flagsQ <= FLAGS_UP;
        end
      end else begin
        addrQ  <= inAddr;
        sizeQ  <= inSize;
        flagsQ <= inFlags;
      end
    end else if (ctl.step) begin
      if (optB) begin
        addrQ <= addrQ + chunkX;
        sizeQ <= sizeQ - chunkX;
      end else begin
        sizeQ <= sizeQ + chunkX;
      end
    end
  end
endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import fill_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdStage,
  input  logic       cmdNonTemp,
  input  logic       cmdUnpriv,
  input  logic       optB,
  input  logic       flagC,
  input  logic       more,
  input  logic       wrAck,
  input  logic       wrFault,
  output dpCtl_t     ctl,
  output stage_e     runStage,
  output logic       busy,
  output logic       done,
  output logic       errUndef,
  output logic       errMismatch,
  output logic       fault,
  output logic       wrValid,
  output logic       wrNonTemp,
  output logic       wrUnpriv
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e state;
  logic   badStage;
  logic   wrongAlgo;

  assign badStage  = (stage_e'(cmdStage) == STG_BAD);
  assign wrongAlgo = !badStage && (stage_e'(cmdStage) != STG_PRO) && (flagC != optB);

  always_comb begin
    ctl.load = (state == S_IDLE) && cmdValid;
    ctl.step = (state == S_RUN) && more && wrAck && !wrFault;
    wrValid  = (state == S_RUN) && more;
    busy     = (state != S_IDLE);
    done     = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      runStage    <= STG_PRO;
      errUndef    <= 1'b0;
      errMismatch <= 1'b0;
      fault       <= 1'b0;
      wrNonTemp   <= 1'b0;
      wrUnpriv    <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (cmdValid) begin
          runStage    <= stage_e'(cmdStage);
          wrNonTemp   <= cmdNonTemp;
          wrUnpriv    <= cmdUnpriv;
          errUndef    <= badStage;
          errMismatch <= wrongAlgo;
          fault       <= 1'b0;
          state       <= (badStage || wrongAlgo) ? S_FIN : S_RUN;
        end
        S_RUN: begin
          if (!more) begin
            state <= S_FIN;
          end else if (wrAck && wrFault) begin
            fault <= 1'b1;
            state <= S_FIN;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fill_seq.sv
module fill_seq
  import fill_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int BEAT_BYTES = 8,
  parameter int MAIN_FLOOR = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdValid,
  input  logic [1:0]              cmdStage,
  input  logic                    cmdNonTemp,
  input  logic                    cmdUnpriv,
  input  logic                    optB,
  input  logic [XLEN-1:0]         inAddr,
  input  logic [XLEN-1:0]         inSize,
  input  logic [7:0]              fillByte,
  input  logic [3:0]              inFlags,
  output logic                    busy,
  output logic                    done,
  output logic                    errUndef,
  output logic                    errMismatch,
  output logic                    fault,
  output logic [XLEN-1:0]         outAddr,
  output logic [XLEN-1:0]         outSize,
  output logic [3:0]              outFlags,
  output logic                    wrValid,
  input  logic                    wrAck,
  input  logic                    wrFault,
  output logic [XLEN-1:0]         wrAddr,
  output logic [8*BEAT_BYTES-1:0] wrData,
  output logic [BEAT_BYTES-1:0]   wrStrb,
  output logic                    wrNonTemp,
  output logic                    wrUnpriv
);
  dpCtl_t ctl;
  stage_e runStage;
  logic   more;

  fill_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdStage   (cmdStage),
    .cmdNonTemp (cmdNonTemp),
    .cmdUnpriv  (cmdUnpriv),
    .optB       (optB),
    .flagC      (inFlags[C_BIT]),
    .more       (more),
    .wrAck      (wrAck),
    .wrFault    (wrFault),
    .ctl        (ctl),
    .runStage   (runStage),
    .busy       (busy),
    .done       (done),
    .errUndef   (errUndef),
    .errMismatch(errMismatch),
    .fault      (fault),
    .wrValid    (wrValid),
    .wrNonTemp  (wrNonTemp),
    .wrUnpriv   (wrUnpriv)
  );

  fill_dp #(
    .XLEN      (XLEN),
    .BEAT_BYTES(BEAT_BYTES),
    .MAIN_FLOOR(MAIN_FLOOR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadStage(cmdStage),
    .runStage (runStage),
    .optB     (optB),
    .inAddr   (inAddr),
    .inSize   (inSize),
    .fillByte (fillByte),
    .inFlags  (inFlags),
    .addrQ    (outAddr),
    .sizeQ    (outSize),
    .flagsQ   (outFlags),
    .more     (more),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .wrStrb   (wrStrb)
  );
endmodule

// File: rtl/fill_seq_chk.sv
module fill_seq_chk #(
  parameter int XLEN       = 64,
  parameter int BEAT_BYTES = 8,
  parameter int MAIN_FLOOR = 64
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    cmdValid,
  input logic [1:0]              cmdStage,
  input logic                    optB,
  input logic [7:0]              fillByte,
  input logic [3:0]              inFlags,
  input logic                    busy,
  input logic                    done,
  input logic                    errUndef,
  input logic                    errMismatch,
  input logic                    fault,
  input logic [XLEN-1:0]         outSize,
  input logic [3:0]              outFlags,
  input logic                    wrValid,
  input logic                    wrAck,
  input logic                    wrFault,
  input logic [XLEN-1:0]         wrAddr,
  input logic [8*BEAT_BYTES-1:0] wrData,
  input logic [BEAT_BYTES-1:0]   wrStrb
);
  logic [1:0] stgSeen;
  logic [7:0] byteSeen;
  logic signed [XLEN-1:0] owed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stgSeen  <= 2'b00;
      byteSeen <= 8'h00;
    end else if (cmdValid && !busy) begin
      stgSeen  <= cmdStage;
      byteSeen <= fillByte;
    end
  end

  assign owed = optB ? $signed(outSize) : -$signed(outSize);

  a_r1_fill_value: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> wrData == {BEAT_BYTES{byteSeen}});

  a_r4_prologue_flags: assert property (@(posedge clk) disable iff (!rstN)  // R3 and R4
    (done && stgSeen == 2'b00 && !fault) |-> outFlags == (optB ? 4'b0010 : 4'b0000));

  a_r7_strobe_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> wrStrb != '0);

  a_r8_main_floor: assert property (@(posedge clk) disable iff (!rstN)
    (done && stgSeen == 2'b01 && !fault && !errMismatch) |-> owed < $signed(XLEN'(MAIN_FLOOR)));

  a_r9_epilogue_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && stgSeen == 2'b10 && !fault && !errMismatch) |-> outSize == '0);

  a_r10_fault_stop: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrAck && wrFault) |=> done && fault && !wrValid);

  a_r11_undef: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdStage == 2'b11) |=> done && errUndef && !wrValid);

  a_r12_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy && cmdStage != 2'b00 && cmdStage != 2'b11 && inFlags[1] != optB)
      |=> done && errMismatch && !wrValid);

  a_r13_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrAck) |=> wrValid && $stable(wrAddr) && $stable(wrStrb) && $stable(wrData));

  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

bind fill_seq fill_seq_chk #(
  .XLEN      (XLEN),
  .BEAT_BYTES(BEAT_BYTES),
  .MAIN_FLOOR(MAIN_FLOOR)
) u_chk (.*);

// File: tb/fill_seq_tb.sv
module fill_seq_tb;
  localparam int        MEMN = 512;
  localparam logic [63:0] BASE = 64'h1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdStage = 2'b00;
  logic        cmdNonTemp = 1'b0;
  logic        cmdUnpriv = 1'b0;
  logic        optB = 1'b0;
  logic [63:0] inAddr = '0;
  logic [63:0] inSize = '0;
  logic [7:0]  fillByte = '0;
  logic [3:0]  inFlags = '0;
  logic        busy, done, errUndef, errMismatch, fault;
  logic [63:0] outAddr, outSize;
  logic [3:0]  outFlags;
  logic        wrValid;
  logic        wrAck = 1'b0;
  logic        wrFault = 1'b0;
  logic [63:0] wrAddr;
  logic [63:0] wrData;
  logic [7:0]  wrStrb;
  logic        wrNonTemp, wrUnpriv;

  fill_seq u_dut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [MEMN];
  int  beatCnt = 0;
  int  faultAt = -1;
  int  stray = 0;
  int  sideBad = 0;
  bit  stall = 1'b0;
  int  cyc = 0;
  logic [63:0] rAddr, rSize;
  logic [3:0]  rFlags;
  logic        rFault, rUndef, rMis;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // memory responder: decides ack/fault for this cycle and commits strobed bytes
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      begin
        bit ackNow;
        bit faultNow;
        ackNow   = !stall || (cyc % 3 != 0);
        faultNow = ackNow && wrValid && (beatCnt == faultAt);
        wrAck    = ackNow;
        wrFault  = faultNow;
        if (wrValid && ackNow) begin
          if (!faultNow) begin
            for (int i = 0; i < 8; i++) begin
              if (wrStrb[i]) begin
                longint off;
                off = longint'(wrAddr + 64'(i) - BASE);
                if (off >= 0 && off < MEMN) mem[off] = wrData[8*i +: 8];
                else stray++;
              end
            end
          end
          if (wrNonTemp != cmdNonTemp || wrUnpriv != cmdUnpriv) sideBad++;
          beatCnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R14 watchdog expired act=%h exp=%h", 64'(cyc), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic prepMem();
    for (int i = 0; i < MEMN; i++) mem[i] = 8'hEE;
    beatCnt = 0;
    stray   = 0;
    sideBad = 0;
    faultAt = -1;
  endtask

  task automatic doStage(input logic [1:0] stg);
    @(negedge clk);
    cmdStage = stg;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!done) @(negedge clk);
    rAddr  = outAddr;
    rSize  = outSize;
    rFlags = outFlags;
    rFault = fault;
    rUndef = errUndef;
    rMis   = errMismatch;
    @(negedge clk);
    chk(!done, "R14", "done longer than one cycle", 64'(done), 64'd0);
  endtask

  task automatic checkMem(input logic [63:0] s, input int len, input logic [7:0] d,
                          input string req);
    int miss;
    miss = 0;
    for (int i = 0; i < MEMN; i++) begin
      logic [7:0] e;
      longint a;
      a = longint'(BASE) + i;
      e = (a >= longint'(s) && a < longint'(s) + len) ? d : 8'hEE;
      if (mem[i] != e) miss++;
    end
    chk(miss == 0 && stray == 0, req, "memory image mismatches", 64'(miss + stray), 64'd0);
  endtask

  task automatic carry();
    inAddr  = rAddr;
    inSize  = rSize;
    inFlags = rFlags;
  endtask

  task automatic runCase(input bit o, input int offs, input int len, input bit stallOn,
                         input logic [7:0] d);
    logic [63:0] s, eAddr, eSize;
    int pro, r, lead;
    string rq;
    s = 64'h1040 + 64'(offs);
    prepMem();
    stall      = stallOn;
    optB       = o;
    cmdNonTemp = (offs % 2 == 1);
    cmdUnpriv  = o;
    fillByte   = d;
    inAddr     = s;
    inSize     = 64'(len);
    inFlags    = 4'b1101;
    doStage(2'b00);
    lead = 8 - (offs % 8);
    pro  = (offs % 8 != 0) ? ((lead < len) ? lead : len) : 0;
    r    = len - pro;
    rq   = o ? "R4" : "R3";
    eAddr = o ? s + 64'(pro) : s + 64'(len);
    eSize = o ? 64'(r) : -64'(r);
    chk(rAddr == eAddr, rq, "prologue address", rAddr, eAddr);
    chk(rSize == eSize, "R7", "prologue stops at word boundary", rSize, eSize);
    chk(rFlags == (o ? 4'b0010 : 4'b0000), rq, "prologue flags", 64'(rFlags),
        o ? 64'd2 : 64'd0);
    carry();
    doStage(2'b01);
    while (r >= 64) r -= 8;
    eAddr = o ? s + 64'(len - r) : s + 64'(len);
    eSize = o ? 64'(r) : -64'(r);
    chk(rSize == eSize, "R8", "main leaves tail below 64", rSize, eSize);
    chk(rAddr == eAddr, o ? "R6" : "R5", "main address", rAddr, eAddr);
    carry();
    doStage(2'b10);
    chk(rSize == 64'd0, "R9", "epilogue size", rSize, 64'd0);
    chk(rAddr == s + 64'(len), o ? "R6" : "R5", "final address", rAddr, s + 64'(len));
    checkMem(s, len, d, "R1");
    chk(sideBad == 0, "R13", "sideband bits", 64'(sideBad), 64'd0);
  endtask

  initial begin
    int lens [12];
    int idx;
    lens = '{0, 1, 3, 7, 8, 9, 15, 63, 64, 65, 71, 130};
    prepMem();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wrValid, "R14", "reset idle", {61'd0, busy, done, wrValid}, 64'd0);

    // R2 saturation, both conventions (aligned start: nothing written in prologue)
    optB = 1'b0; inAddr = BASE; inSize = 64'hFFFF_0000_0000_0000; fillByte = 8'h5A;
    doStage(2'b00);
    chk(rSize == 64'h8000_0000_0000_0001, "R2", "saturated negated size", rSize,
        64'h8000_0000_0000_0001);
    chk(rAddr == 64'h8000_0000_0000_0FFF, "R2", "saturated end address", rAddr,
        64'h8000_0000_0000_0FFF);
    optB = 1'b1; inAddr = BASE; inSize = 64'hFFFF_0000_0000_0000;
    doStage(2'b00);
    chk(rSize == 64'h7FFF_FFFF_FFFF_FFFF, "R2", "saturated size", rSize,
        64'h7FFF_FFFF_FFFF_FFFF);
    chk(rFlags == 4'b0010 && beatCnt == 0, "R4", "count-down flags, no write",
        {rFlags, 28'd0, 32'(beatCnt)}, 64'h2000_0000_0000_0000);

    // R11 undefined stage code
    prepMem();
    optB = 1'b0; inAddr = 64'h1234; inSize = 64'd5; inFlags = 4'b1010;
    doStage(2'b11);
    chk(rUndef && beatCnt == 0, "R11", "undefined stage flagged, no write",
        {63'd0, rUndef}, 64'd1);
    chk(rAddr == 64'h1234 && rSize == 64'd5 && rFlags == 4'b1010, "R11",
        "registers untouched", rSize, 64'd5);

    // R12 carry/strap mismatch
    inAddr = 64'h1040; inSize = -64'd100; inFlags = 4'b0010;
    doStage(2'b01);
    chk(rMis && beatCnt == 0 && rSize == -64'd100, "R12", "count-up strap, C=1",
        rSize, -64'd100);
    optB = 1'b1; inAddr = 64'h1040; inSize = 64'd30; inFlags = 4'b0000;
    doStage(2'b10);
    chk(rMis && beatCnt == 0 && rSize == 64'd30 && rAddr == 64'h1040, "R12",
        "count-down strap, C=0", rSize, 64'd30);

    // R10 fault on second beat, count-down form
    prepMem();
    optB = 1'b1; fillByte = 8'hC3; inAddr = 64'h1040; inSize = 64'd20;
    inFlags = 4'b0010; faultAt = 1;
    doStage(2'b10);
    chk(rFault && rAddr == 64'h1048, "R10", "count-down fault address", rAddr, 64'h1048);
    chk(rSize == 64'd12, "R10", "count-down fault size", rSize, 64'd12);
    checkMem(64'h1040, 8, 8'hC3, "R10");

    // R10 fault then resume, count-up form
    prepMem();
    optB = 1'b0; fillByte = 8'h3C; inAddr = 64'h1054; inSize = -64'd20;
    inFlags = 4'b0000; faultAt = 1;
    doStage(2'b10);
    chk(rFault && rAddr == 64'h1054 && rSize == -64'd12, "R10", "count-up fault state",
        rSize, -64'd12);
    faultAt = -1;
    carry();
    doStage(2'b10);
    chk(!rFault && rSize == 64'd0, "R10", "resumed epilogue completes", rSize, 64'd0);
    checkMem(64'h1040, 20, 8'h3C, "R10");

    // sweep both conventions, start offsets, lengths, back-pressure
    idx = 0;
    for (int o = 0; o < 2; o++) begin
      for (int offs = 0; offs < 10; offs++) begin
        for (int li = 0; li < 12; li++) begin
          runCase(o[0], offs, lens[li], idx[0], 8'(idx * 37 + 1));
          idx++;
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule